// File: doc/BRIEF.md
# Unsigned Byte Multiply Unit

This unit executes the unsigned byte-by-byte multiply instruction of a small 8-bit processor core. The issue stage presents the 16-bit instruction word together with a start strobe. The unit decodes the two register indices from that word and drives them out to the register file's read ports. The register file returns the two operand bytes on the same cycle, together with the current status byte. All of these inputs are captured on the accepting clock edge.

The unit always delivers the 16-bit product to the fixed register pair 0 and 1, whatever the operand indices are. The low byte goes to register 0 and the high byte to register 1. Both write strobes and a done pulse assert together, two cycles after the cycle in which the start was presented.

The status byte comes back with two changes. The carry flag takes the top bit of the product, and the zero flag reports an all-zero product. Every other status bit returns exactly as it was captured. Because the inputs are latched at the start, the unit's own write into registers 0 and 1 cannot disturb an operation that is already running.

Top module: `mul8_unit`

## Requirements
- R1: A start is accepted only when `start` is high, `instr[15:10]` equals 6'b100111, and the unit is not in its computing cycle (the cycle directly after an accepted start).
- R2: The product `{prod_hi, prod_lo}` equals the unsigned product of the `rd_byte` value and the `rr_byte` value sampled at the accepting edge.
- R3: `done` is high for exactly one cycle. That cycle is the second cycle after the cycle in which an accepted start was presented.
- R4: `wr_en_r0` (low byte, register 0) and `wr_en_r1` (high byte, register 1) are high exactly in the cycles where `done` is high, and never otherwise.
- R5: In the done cycle, `status_out[0]` (carry) equals bit 15 of the product.
- R6: In the done cycle, `status_out[1]` (zero) is 1 when the whole 16-bit product is zero, and 0 otherwise.
- R7: In the done cycle, `status_out[7:2]` equal `status_in[7:2]` as sampled at the accepting edge.
- R8: Changes to `rd_byte`, `rr_byte` or `status_in` after the accepting edge have no effect on the result of that operation.
- R9: A start presented during the computing cycle is ignored. The running result is delivered unchanged, and no second done pulse follows.
- R10: A start whose `instr[15:10]` differs from 6'b100111 is ignored. No done pulse follows, and the result outputs keep their previous values.
- R11: After synchronous active-low reset, `done`, both write enables, `prod_lo`, `prod_hi` and `status_out` are all zero.
- R12: A new start may be accepted in the done cycle, giving one result every two cycles.
- R13: `src_d_idx` equals `instr[8:4]`, and `src_r_idx` equals `{instr[9], instr[3:0]}`. Both are combinational from `instr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Issue strobe for the instruction on `instr` |
| instr | input | 16 | Instruction word |
| rd_byte | input | 8 | Operand byte read from the register selected by `src_d_idx` |
| rr_byte | input | 8 | Operand byte read from the register selected by `src_r_idx` |
| status_in | input | 8 | Current status byte |
| src_d_idx | output | 5 | First operand register index, decoded from `instr` |
| src_r_idx | output | 5 | Second operand register index, decoded from `instr` |
| prod_lo | output | 8 | Low product byte, destined for register 0 |
| prod_hi | output | 8 | High product byte, destined for register 1 |
| wr_en_r0 | output | 1 | Write strobe for register 0 |
| wr_en_r1 | output | 1 | Write strobe for register 1 |
| status_out | output | 8 | Updated status byte, valid with `done` |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The bench aims at the carry flag with products whose bit 15 differs from other likely candidates. 0x80*0x80 gives 0x4000, and 0xFF*0x81 gives 0x807F. A design that took carry from bit 7 or from an overflow out of 16 bits would report the wrong flag on these. Zero and 255*255 operands check the zero flag and the full-width product, and a status byte with all upper bits set shows whether anything beyond C and Z is being overwritten. The operand inputs are altered during the computing cycle, and starts are fired mid-operation and with a foreign opcode. A design that used live operands, restarted when busy, or ignored the opcode would give a wrong product, a stray done pulse or a changed output. A back-to-back issue in the done cycle shows whether the unit wrongly stalls for a third cycle.

// File: rtl/mul8_pkg.sv
// Package: shared constants, state type and opcode test for the byte multiply unit.
// Assumes the 6 leading instruction bits identify the unsigned multiply.
package mul8_pkg;
    localparam int unsigned INSTR_W  = 16;
    localparam int unsigned OPC_MSB  = 15;
    localparam int unsigned OPC_LSB  = 10;
    localparam int unsigned OPC_W    = OPC_MSB - OPC_LSB + 1;
    localparam logic [OPC_W-1:0] MUL_OPC = 6'b100111;
    localparam int unsigned IDX_W    = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_e;

    // True when the word carries the unsigned multiply opcode.
    function automatic logic is_mul_word(input logic [INSTR_W-1:0] w);
        return w[OPC_MSB:OPC_LSB] == MUL_OPC;
    endfunction
endpackage

// File: rtl/mul8_decode.sv
// Module: splits the instruction word into opcode match and operand indices.
// Assumes the first index sits in bits 8:4 and the second in {9, 3:0}.
module mul8_decode
    import mul8_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic               opc_ok,
    output logic [IDX_W-1:0]   d_idx,
    output logic [IDX_W-1:0]   r_idx
);
    // Pure field extraction and opcode compare.
    always_comb begin
        opc_ok = is_mul_word(instr);
        d_idx  = instr[8:4];
        r_idx  = {instr[9], instr[3:0]};
    end
endmodule

// File: rtl/mul8_array.sv
// Module: combinational unsigned W x W multiplier built from shifted partial products.
// Assumes operands are unsigned; result is 2W bits and never overflows.
module mul8_array #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] pp [W];

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_pp
            // One partial product row per multiplier bit.
            assign pp[gi] = b[gi] ? (PW'(a) << gi) : '0;
        end
    endgenerate

    // Accumulate the partial product rows.
    always_comb begin
        p = '0;
        for (int i = 0; i < W; i++) begin
            p = p + pp[i];
        end
    end
endmodule

// File: rtl/mul8_flags.sv
// Module: merges product-derived carry and zero into a captured status byte.
// Assumes carry and zero positions are distinct and inside the status width.
module mul8_flags #(
    parameter int unsigned W     = 8,
    parameter int unsigned SW    = 8,
    parameter int unsigned C_POS = 0,
    parameter int unsigned Z_POS = 1
) (
    input  logic [2*W-1:0] prod,
    input  logic [SW-1:0]  st_in,
    output logic [SW-1:0]  st_out
);
    // Replace only carry and zero, keep every other bit.
    always_comb begin
        st_out        = st_in;
        st_out[C_POS] = prod[2*W-1];
        st_out[Z_POS] = (prod == '0);
    end
endmodule

// File: rtl/mul8_ctrl.sv
// Module: sequencer giving a fixed two-cycle latency from accepted start to done.
// Assumes a start is only meaningful with a matching opcode; synchronous active-low reset.
module mul8_ctrl
    import mul8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic opc_ok,
    output logic capture,
    output logic load,
    output logic busy,
    output logic done,
    output logic wr_lo,
    output logic wr_hi
);
    mul_state_e state_q, state_d;
    logic       wr_q;

    // Accept decision and computing-cycle indication.
    always_comb begin
        busy    = (state_q == ST_MUL);
        capture = start && opc_ok && !busy;
        load    = busy;
        done    = (state_q == ST_DONE);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = capture ? ST_MUL : ST_IDLE;
            ST_MUL:  state_d = ST_DONE;
            ST_DONE: state_d = capture ? ST_MUL : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Register write strobes, raised when the product is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b0;
        else        wr_q <= load;
    end

    assign wr_lo = wr_q;
    assign wr_hi = wr_q;
endmodule

// File: rtl/mul8_unit.sv
// Module: top of the unsigned byte multiply unit.
// Captures operands and status on an accepted start, computes in the next cycle,
// and presents the product for registers 0/1 with updated status in the cycle after.
// Assumes the register file reads the bytes addressed by src_d_idx/src_r_idx combinationally.
module mul8_unit
    import mul8_pkg::*;
#(
    parameter int unsigned W     = 8,
    parameter int unsigned SW    = 8,
    parameter int unsigned C_POS = 0,
    parameter int unsigned Z_POS = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    input  logic [W-1:0]       rd_byte,
    input  logic [W-1:0]       rr_byte,
    input  logic [SW-1:0]      status_in,
    output logic [IDX_W-1:0]   src_d_idx,
    output logic [IDX_W-1:0]   src_r_idx,
    output logic [W-1:0]       prod_lo,
    output logic [W-1:0]       prod_hi,
    output logic               wr_en_r0,
    output logic               wr_en_r1,
    output logic [SW-1:0]      status_out,
    output logic               done
);
    localparam int unsigned PW = 2 * W;

    logic          opc_ok, capture, load, busy;
    logic [W-1:0]  op_a_q, op_b_q;
    logic [SW-1:0] st_q;
    logic [PW-1:0] prod_c, prod_q;
    logic [SW-1:0] st_c, st_out_q;

    mul8_decode u_dec (
        .instr  (instr),
        .opc_ok (opc_ok),
        .d_idx  (src_d_idx),
        .r_idx  (src_r_idx)
    );

    mul8_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .opc_ok  (opc_ok),
        .capture (capture),
        .load    (load),
        .busy    (busy),
        .done    (done),
        .wr_lo   (wr_en_r0),
        .wr_hi   (wr_en_r1)
    );

    // Latch operands and status on the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_a_q <= '0;
            op_b_q <= '0;
            st_q   <= '0;
        end else if (capture) begin
            op_a_q <= rd_byte;
            op_b_q <= rr_byte;
            st_q   <= status_in;
        end
    end

    mul8_array #(.W(W)) u_mul (
        .a (op_a_q),
        .b (op_b_q),
        .p (prod_c)
    );

    mul8_flags #(.W(W), .SW(SW), .C_POS(C_POS), .Z_POS(Z_POS)) u_flags (
        .prod   (prod_c),
        .st_in  (st_q),
        .st_out (st_c)
    );

    // Register the product and status at the end of the computing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q   <= '0;
            st_out_q <= '0;
        end else if (load) begin
            prod_q   <= prod_c;
            st_out_q <= st_c;
        end
    end

    assign prod_lo    = prod_q[W-1:0];
    assign prod_hi    = prod_q[PW-1:W];
    assign status_out = st_out_q;
endmodule

// File: rtl/mul8_unit_chk.sv
// Module: assertion checker for mul8_unit, attached by bind.
module mul8_unit_chk
    import mul8_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned SW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [INSTR_W-1:0] instr,
    input logic [W-1:0]       rd_byte,
    input logic [W-1:0]       rr_byte,
    input logic [SW-1:0]      status_in,
    input logic [W-1:0]       prod_lo,
    input logic [W-1:0]       prod_hi,
    input logic               wr_en_r0,
    input logic               wr_en_r1,
    input logic [SW-1:0]      status_out,
    input logic               done,
    input logic               busy
);
    logic accept;
    assign accept = start && (instr[OPC_MSB:OPC_LSB] == MUL_OPC) && !busy;

    AST_ACCEPT_ENTERS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy); // R1
    AST_PRODUCT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ({prod_hi, prod_lo} == (16'($past(rd_byte, 2)) * 16'($past(rr_byte, 2))))); // R2
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 done); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_en_r0 && wr_en_r1)); // R4
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!wr_en_r0 && !wr_en_r1)); // R4
    AST_CARRY_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status_out[0] == prod_hi[W-1])); // R5
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status_out[1] == ({prod_hi, prod_lo} == '0))); // R6
    AST_KEEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status_out[SW-1:2] == $past(status_in[SW-1:2], 2))); // R7
    AST_DONE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R10
endmodule

bind mul8_unit mul8_unit_chk #(.W(W), .SW(SW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .instr      (instr),
    .rd_byte    (rd_byte),
    .rr_byte    (rr_byte),
    .status_in  (status_in),
    .prod_lo    (prod_lo),
    .prod_hi    (prod_hi),
    .wr_en_r0   (wr_en_r0),
    .wr_en_r1   (wr_en_r1),
    .status_out (status_out),
    .done       (done),
    .busy       (busy)
);

// File: tb/tb_mul8_unit.sv
module tb_mul8_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [7:0]  rd_byte = '0, rr_byte = '0, status_in = '0;
    logic [4:0]  src_d_idx, src_r_idx;
    logic [7:0]  prod_lo, prod_hi, status_out;
    logic        wr_en_r0, wr_en_r1, done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mul8_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .rd_byte(rd_byte), .rr_byte(rr_byte), .status_in(status_in),
        .src_d_idx(src_d_idx), .src_r_idx(src_r_idx),
        .prod_lo(prod_lo), .prod_hi(prod_hi),
        .wr_en_r0(wr_en_r0), .wr_en_r1(wr_en_r1),
        .status_out(status_out), .done(done)
    );

    function automatic logic [15:0] mk_mul(input logic [4:0] d, input logic [4:0] r);
        return {6'b100111, r[4], d, r[3:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    // Present an accepted start for one cycle; returns in the computing cycle.
    task automatic launch(input logic [7:0] a, input logic [7:0] b, input logic [7:0] st,
                          input logic [4:0] d, input logic [4:0] r);
        @(negedge clk);
        start = 1'b1; instr = mk_mul(d, r);
        rd_byte = a; rr_byte = b; status_in = st;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Check the done cycle against an independently computed result.
    task automatic expect_result(input string tag, input logic [7:0] a, input logic [7:0] b,
                                 input logic [7:0] st);
        logic [15:0] p;
        logic [7:0]  es;
        p  = 16'(a) * 16'(b);
        es = {st[7:2], (p == 16'h0), p[15]};
        chk({tag, " R3 done"}, done, 1);
        chk({tag, " R4 we0"}, wr_en_r0, 1);
        chk({tag, " R4 we1"}, wr_en_r1, 1);
        chk({tag, " R2 lo"}, prod_lo, p[7:0]);
        chk({tag, " R2 hi"}, prod_hi, p[15:8]);
        chk({tag, " R5 carry"}, status_out[0], p[15]);
        chk({tag, " R6 zero"}, status_out[1], p == 16'h0);
        chk({tag, " R7 status"}, status_out, es);
    endtask

    task automatic t_reset();
        chk("R11 done", done, 0);
        chk("R11 we0", wr_en_r0, 0);
        chk("R11 we1", wr_en_r1, 0);
        chk("R11 lo", prod_lo, 0);
        chk("R11 hi", prod_hi, 0);
        chk("R11 status", status_out, 0);
    endtask

    task automatic t_decode();
        @(negedge clk);
        instr = mk_mul(5'd19, 5'd26);
        #1;
        chk("R13 d idx", src_d_idx, 19);
        chk("R13 r idx", src_r_idx, 26);
        instr = mk_mul(5'd7, 5'd15);
        #1;
        chk("R13 d idx", src_d_idx, 7);
        chk("R13 r idx", src_r_idx, 15);
    endtask

    task automatic t_one(input logic [7:0] a, input logic [7:0] b, input logic [7:0] st);
        launch(a, b, st, 5'd2, 5'd3);
        @(negedge clk);
        expect_result("basic", a, b, st);
        @(negedge clk);
        chk("R3 single pulse", done, 0);
        chk("R4 we0 low", wr_en_r0, 0);
    endtask

    task automatic t_capture();
        launch(8'h2B, 8'h11, 8'hFC, 5'd0, 5'd1);
        rd_byte = 8'hFF; rr_byte = 8'hFF; status_in = 8'h00;
        @(negedge clk);
        expect_result("R8 capture", 8'h2B, 8'h11, 8'hFC);
    endtask

    task automatic t_busy_start();
        launch(8'h0C, 8'h0D, 8'h40, 5'd4, 5'd5);
        start = 1'b1; instr = mk_mul(5'd6, 5'd7);
        rd_byte = 8'h99; rr_byte = 8'h77; status_in = 8'h80;
        @(negedge clk);
        start = 1'b0;
        expect_result("R9 busy", 8'h0C, 8'h0D, 8'h40);
        @(negedge clk);
        chk("R9 no second done", done, 0);
        @(negedge clk);
        chk("R9 no late done", done, 0);
        chk("R9 lo kept", prod_lo, 8'h9C);
    endtask

    task automatic t_bad_opcode();
        @(negedge clk);
        start = 1'b1; instr = 16'h9400; rd_byte = 8'h55; rr_byte = 8'h03; status_in = 8'h00;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R10 no done", done, 0);
            @(negedge clk);
        end
        chk("R10 lo unchanged", prod_lo, 8'h9C);
        chk("R10 hi unchanged", prod_hi, 8'h00);
    endtask

    task automatic t_back_to_back();
        launch(8'h12, 8'h34, 8'h00, 5'd8, 5'd9);
        @(negedge clk);
        expect_result("R12 first", 8'h12, 8'h34, 8'h00);
        start = 1'b1; instr = mk_mul(5'd10, 5'd11);
        rd_byte = 8'hFE; rr_byte = 8'hFD; status_in = 8'hA8;
        @(negedge clk);
        start = 1'b0;
        chk("R12 gap", done, 0);
        @(negedge clk);
        expect_result("R12 second", 8'hFE, 8'hFD, 8'hA8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_decode();
        t_one(8'd3, 8'd5, 8'h00);
        t_one(8'hFF, 8'hFF, 8'hA4);
        t_one(8'h00, 8'h7E, 8'h5C);
        t_one(8'h80, 8'h80, 8'hFF);
        t_one(8'hFF, 8'h81, 8'h03);
        t_one(8'h80, 8'h02, 8'hFC);
        t_capture();
        t_busy_start();
        t_bad_opcode();
        t_back_to_back();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule